// File: doc/BRIEF.md
# Two-Wire Four-Phase Handshake Transfer Controller

This block moves parallel words between two units that share no common timing reference. Each unit uses a pair of control wires. The block holds two engines. A sending engine drives a data bus, a bus-enable and a data-valid wire, and listens to one reply wire from its peer. A receiving engine listens to a data bus and a data-valid wire, and drives one reply wire. A single mode input chooses the meaning of the reply wire for both engines.

In source-initiated mode the reply wire means "data accepted". In destination-initiated mode it means "ready for data". Every handshake step may take any number of cycles, so the slower side sets the rate. Both handshake inputs cross two synchronizer flops before either state machine sees them.

Each engine has a watchdog. If the peer stays silent for a parameter number of cycles, the engine releases its wires, goes back to idle and raises an error flag. The flag stays set until reset. The mode may change only while both engines are idle.

Top module: `hs_xfer_ctrl`

## Requirements
- R1: After reset these outputs are all low or zero: valid_o, bus_oe_o, bus_data_o, reply_o, both done pulses, both error flags and dst_word_o.
- R2: The sending engine drives its word with bus_oe_o high for at least one cycle before it raises valid_o. valid_o is never high while bus_oe_o is low.
- R3: In source-initiated mode (mode_i = 0), an enabled receiving engine that sees valid_o high captures bus_data_i and raises reply_o. It drops reply_o once valid falls. In the same mode the sending engine drops valid_o and bus_oe_o after it sees the reply, and it completes only after the reply falls.
- R4: In destination-initiated mode (mode_i = 1), an enabled receiving engine raises reply_o as its ready signal. The sending engine keeps bus_oe_o and valid_o low until the reply is seen high.
- R5: In destination-initiated mode, the receiving engine captures the word and drops reply_o when it sees valid. The sending engine holds valid_o until it sees the reply fall. It then drops valid_o and bus_oe_o and completes.
- R6: Each engine gives a one-cycle done pulse per completed word. dst_word_o holds the last captured word until the next capture.
- R7: A sending engine whose peer does not answer for TIMEOUT_CYC cycles of one waiting step sets src_err_o and releases valid_o and bus_oe_o in the same cycle. In source-initiated mode the error appears on the (TIMEOUT_CYC+1)-th rising edge after the edge that samples the start.
- R8: A receiving engine whose peer stalls for TIMEOUT_CYC cycles sets dst_err_o and drops reply_o. In source-initiated mode, with valid_i held high, this happens on the (TIMEOUT_CYC+2)-th rising edge after the edge that first samples valid_i high.
- R9: Both error flags stay set until reset. Later transfers still complete while a flag is set.
- R10: In source-initiated mode a receiving engine with dst_en_i low ignores valid_i. reply_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = source-initiated, 1 = destination-initiated |
| src_start_i | input | 1 | Begin sending src_word_i (sampled while the sender is idle) |
| src_word_i | input | DATA_W | Word to send |
| src_busy_o | output | 1 | Sending engine is not idle |
| src_done_o | output | 1 | One-cycle pulse when a word has been sent |
| src_err_o | output | 1 | Sticky sender timeout flag |
| bus_data_o | output | DATA_W | Outgoing data bus, zero when released |
| bus_oe_o | output | 1 | Outgoing data bus drive enable |
| valid_o | output | 1 | Outgoing data-valid wire |
| peer_reply_i | input | 1 | Reply from the remote receiver (accepted or ready) |
| dst_en_i | input | 1 | Receiving engine may take words |
| bus_data_i | input | DATA_W | Incoming data bus |
| valid_i | input | 1 | Incoming data-valid wire |
| reply_o | output | 1 | Reply to the remote sender (accepted or ready) |
| dst_word_o | output | DATA_W | Last captured word |
| dst_done_o | output | 1 | One-cycle pulse when a word has been received |
| dst_err_o | output | 1 | Sticky receiver timeout flag |

## Verification
A change on peer_reply_i or valid_i first moves a state machine on the third rising edge after it is driven: two edges for the synchronizer and one for the state register. A start takes effect on the first edge. A timeout takes effect on the exact edge given in R7 and R8. The directed tests drive each input just after an edge. They then step a counted number of edges and sample at the edge before and the edge after each expected change. The loopback vector transfers have no fixed latency, so they poll for both done pulses within a bounded window and then compare the captured word.

// File: rtl/hs_pkg.sv
package hs_pkg;
   localparam logic MODE_SRC_INIT = 1'b0;
   localparam logic MODE_DST_INIT = 1'b1;

   typedef enum logic [2:0] {
      S_IDLE, S_WREQ, S_PLACE, S_VALID, S_REL
   } src_st_t;

   typedef enum logic [1:0] {
      D_IDLE, D_RDY, D_ACK, D_HOLD
   } dst_st_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_wdog.sv
module hs_wdog #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad
         $error("hs_wdog: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign expire = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (kick || !run)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hs_src.sv
module hs_src
   import hs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              start,
   input  logic [DATA_W-1:0] word,
   input  logic              reply_s,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_oe,
   output logic              valid,
   output logic              busy,
   output logic              done,
   output logic              err
);
   src_st_t           st_q, st_n;
   logic              m_q;
   logic [DATA_W-1:0] word_q;
   logic              waiting, expire, fin;

   assign waiting = (st_q == S_WREQ) || (st_q == S_VALID) || (st_q == S_REL);

   hs_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(waiting),
      .kick(st_n != st_q), .expire(expire)
   );

   always_comb begin
      st_n = st_q;
      fin  = 1'b0;
      unique case (st_q)
         S_IDLE:  if (start) st_n = (mode == MODE_DST_INIT) ? S_WREQ : S_PLACE;
         S_WREQ:  if (reply_s) st_n = S_PLACE;
         S_PLACE: st_n = S_VALID;
         S_VALID: begin
            if (m_q == MODE_SRC_INIT) begin
               if (reply_s) st_n = S_REL;
            end else if (!reply_s) begin
               st_n = S_IDLE;
               fin  = 1'b1;
            end
         end
         S_REL: if (!reply_s) begin
            st_n = S_IDLE;
            fin  = 1'b1;
         end
         default: st_n = S_IDLE;
      endcase
      if (expire) begin
         st_n = S_IDLE;
         fin  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         m_q    <= MODE_SRC_INIT;
         word_q <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         st_q <= st_n;
         done <= fin;
         if (expire) err <= 1'b1;
         if (st_q == S_IDLE && start) begin
            m_q    <= mode;
            word_q <= word;
         end
      end
   end

   assign bus_oe   = (st_q == S_PLACE) || (st_q == S_VALID);
   assign bus_data = bus_oe ? word_q : '0;
   assign valid    = (st_q == S_VALID);
   assign busy     = (st_q != S_IDLE);

   a_r2_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> bus_oe);
   a_r2_data_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(bus_oe));
   a_r6_src_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_src_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   a_r7_src_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!valid && !bus_oe));
endmodule

// File: rtl/hs_dst.sv
module hs_dst
   import hs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              en,
   input  logic              valid_s,
   input  logic [DATA_W-1:0] bus_data,
   output logic              reply,
   output logic [DATA_W-1:0] word,
   output logic              done,
   output logic              err
);
   dst_st_t st_q, st_n;
   logic    m_q;
   logic    waiting, expire, cap, fin;

   assign waiting = (st_q != D_IDLE);

   hs_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(waiting),
      .kick(st_n != st_q), .expire(expire)
   );

   always_comb begin
      st_n = st_q;
      cap  = 1'b0;
      fin  = 1'b0;
      unique case (st_q)
         D_IDLE: if (en) begin
            if (mode == MODE_DST_INIT) st_n = D_RDY;
            else if (valid_s) begin
               st_n = D_ACK;
               cap  = 1'b1;
            end
         end
         D_RDY: begin
            if (valid_s) begin
               st_n = D_HOLD;
               cap  = 1'b1;
            end else if (!en) st_n = D_IDLE;
         end
         D_ACK, D_HOLD: if (!valid_s) begin
            st_n = D_IDLE;
            fin  = 1'b1;
         end
         default: st_n = D_IDLE;
      endcase
      if (expire) begin
         st_n = D_IDLE;
         cap  = 1'b0;
         fin  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= D_IDLE;
         m_q  <= MODE_SRC_INIT;
         word <= '0;
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         st_q <= st_n;
         done <= fin;
         if (expire) err <= 1'b1;
         if (cap) word <= bus_data;
         if (st_q == D_IDLE) m_q <= mode;
      end
   end

   assign reply = (st_q == D_ACK) || (st_q == D_RDY && m_q == MODE_DST_INIT);

   a_r6_dst_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(word));
   a_r9_dst_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   a_r8_dst_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !reply);
endmodule

// File: rtl/hs_xfer_ctrl.sv
module hs_xfer_ctrl #(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              src_start_i,
   input  logic [DATA_W-1:0] src_word_i,
   output logic              src_busy_o,
   output logic              src_done_o,
   output logic              src_err_o,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_oe_o,
   output logic              valid_o,
   input  logic              peer_reply_i,
   input  logic              dst_en_i,
   input  logic [DATA_W-1:0] bus_data_i,
   input  logic              valid_i,
   output logic              reply_o,
   output logic [DATA_W-1:0] dst_word_o,
   output logic              dst_done_o,
   output logic              dst_err_o
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("hs_xfer_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic reply_s, valid_s;

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_reply (
      .clk(clk), .rst_n(rst_n), .d(peer_reply_i), .q(reply_s));
   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_valid (
      .clk(clk), .rst_n(rst_n), .d(valid_i), .q(valid_s));

   hs_src #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_src (
      .clk(clk), .rst_n(rst_n), .mode(mode_i), .start(src_start_i),
      .word(src_word_i), .reply_s(reply_s), .bus_data(bus_data_o),
      .bus_oe(bus_oe_o), .valid(valid_o), .busy(src_busy_o),
      .done(src_done_o), .err(src_err_o));

   hs_dst #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_dst (
      .clk(clk), .rst_n(rst_n), .mode(mode_i), .en(dst_en_i),
      .valid_s(valid_s), .bus_data(bus_data_i), .reply(reply_o),
      .word(dst_word_o), .done(dst_done_o), .err(dst_err_o));
endmodule

// File: tb/tb_hs_xfer_ctrl.sv
module tb_hs_xfer_ctrl;
   localparam int DW = 8;
   localparam int TO = 20;
   localparam int NV = 6;
   // {mode, word}; the expected captured word equals the word sent
   localparam logic [DW:0] VEC [NV] = '{
      9'h0A5, 9'h000, 9'h0FF, 9'h13C, 9'h181, 9'h17E };

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic mode, start, dst_en, loop_on, tb_reply, tb_valid;
   logic [DW-1:0] word, tb_data;
   logic src_busy, src_done, src_err, bus_oe, valid_o, reply_o, dst_done, dst_err;
   logic [DW-1:0] bus_data_o, dst_word;
   logic peer_reply, valid_in;
   logic [DW-1:0] data_in;

   assign peer_reply = loop_on ? reply_o    : tb_reply;
   assign valid_in   = loop_on ? valid_o    : tb_valid;
   assign data_in    = loop_on ? bus_data_o : tb_data;

   hs_xfer_ctrl #(.DATA_W(DW), .TIMEOUT_CYC(TO)) dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .src_start_i(start),
      .src_word_i(word), .src_busy_o(src_busy), .src_done_o(src_done),
      .src_err_o(src_err), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe),
      .valid_o(valid_o), .peer_reply_i(peer_reply), .dst_en_i(dst_en),
      .bus_data_i(data_in), .valid_i(valid_in), .reply_o(reply_o),
      .dst_word_o(dst_word), .dst_done_o(dst_done), .dst_err_o(dst_err));

   int runs = 0, fails = 0;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 0; mode = 0; start = 0; dst_en = 0; loop_on = 1;
      tb_reply = 0; tb_valid = 0; word = '0; tb_data = '0;
      step(3);
      rst_n = 1;
      step(1);
   endtask

   task automatic xfer(input logic m, input logic [DW-1:0] w, output bit sd, output bit dd);
      sd = 0; dd = 0;
      mode = m; word = w; start = 1;
      step(1);
      start = 0;
      for (int i = 0; i < 100 && !(sd && dd); i++) begin
         step(1);
         if (src_done) sd = 1;
         if (dst_done) dd = 1;
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin
      bit sd, dd;
      do_reset();
      // R1 reset state
      chk(valid_o, 0, "R1 valid"); chk(bus_oe, 0, "R1 oe");
      chk(bus_data_o, 0, "R1 bus"); chk(reply_o, 0, "R1 reply");
      chk(src_err, 0, "R1 src_err"); chk(dst_err, 0, "R1 dst_err");
      chk(dst_word, 0, "R1 word");
      chk(src_done, 0, "R1 src_done"); chk(dst_done, 0, "R1 dst_done");

      // vector table: loopback transfers, R3 (mode 0) and R5 (mode 1)
      dst_en = 1;
      for (int v = 0; v < NV; v++) begin
         xfer(VEC[v][DW], VEC[v][DW-1:0], sd, dd);
         chk(sd, 1, VEC[v][DW] ? "R5 src done" : "R3 src done");
         chk(dd, 1, "R6 dst done");
         chk(dst_word, VEC[v][DW-1:0], VEC[v][DW] ? "R5 word" : "R3 word");
         chk({src_err, dst_err}, 0, "R9 no error");
      end
      dst_en = 0;
      step(10);
      chk(dst_word, 8'h7E, "R6 word held");
      chk(reply_o, 0, "R6 reply low after disable");

      // R10: disabled receiver ignores valid in mode 0
      do_reset();
      loop_on = 0; tb_valid = 1; tb_data = 8'h55;
      step(8);
      chk(reply_o, 0, "R10 reply ignored");
      chk(dst_word, 0, "R10 no capture");
      tb_valid = 0;

      // R7: sender timeout, mode 0, no reply ever
      do_reset();
      loop_on = 0; word = 8'h11; start = 1;
      step(1);
      start = 0;
      step(TO);
      chk(src_err, 0, "R7 err not yet");
      chk({valid_o, bus_oe}, 2'b11, "R7 still driving");
      step(1);
      chk(src_err, 1, "R7 err set");
      chk({valid_o, bus_oe}, 2'b00, "R7 released");
      chk(bus_data_o, 0, "R7 bus zero");

      // R9: sticky error, later transfer still works
      loop_on = 1; dst_en = 1;
      xfer(1'b0, 8'h5A, sd, dd);
      chk(src_err, 1, "R9 err sticky");
      chk(dst_word, 8'h5A, "R9 transfer after error");

      // R8: receiver timeout, mode 0, valid held high
      do_reset();
      loop_on = 0; dst_en = 1; tb_data = 8'hC3; tb_valid = 1;
      step(1);
      step(TO + 1);
      chk(dst_err, 0, "R8 err not yet");
      chk(reply_o, 1, "R8 accepted high");
      chk(dst_word, 8'hC3, "R3 capture");
      step(1);
      chk(dst_err, 1, "R8 err set");
      chk(reply_o, 0, "R8 reply released");
      tb_valid = 0;

      // R4/R5: sender in mode 1 waits for ready, then drops after ready falls
      do_reset();
      loop_on = 0; mode = 1; word = 8'h99; start = 1;
      step(1);
      start = 0;
      step(5);
      chk({bus_oe, valid_o}, 2'b00, "R4 waits for ready");
      tb_reply = 1;
      step(3);
      chk({bus_oe, valid_o}, 2'b10, "R2 data placed first");
      chk(bus_data_o, 8'h99, "R4 bus word");
      step(1);
      chk(valid_o, 1, "R2 valid raised");
      tb_reply = 0;
      step(2);
      chk(valid_o, 1, "R5 valid held");
      step(1);
      chk({bus_oe, valid_o}, 2'b00, "R5 released");
      chk(src_done, 1, "R6 done pulse");
      step(1);
      chk(src_done, 0, "R6 done one cycle");

      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule